// File: doc/BRIEF.md
# Front-Panel Light Sequencer

This block drives a short row of status LEDs by itself so that the host processor spends no instructions keeping them alive. The host picks one of five behaviours through a mode code: all dark, a built-in walking light, direct manual control, recording a sequence of patterns, and looping playback of what was recorded. A separate enable line blanks the row whatever the mode.

The host talks to the block through a pattern bus with a one-cycle write strobe and a step-rate tick. In manual mode a strobe sets the row at once. In learn mode each strobe appends one pattern to a small internal pattern memory. In replay mode the recorded patterns are shown one after another, one per tick, and the sequence starts again after its last entry. The tick can come from any divider, so the step rate is set outside the block. The LED vector is driven combinationally from the block's registers and the current mode and enable inputs.

Top module: `led_seq_top`

## Requirements
- R1: After reset the recording is empty, the manual pattern is 0000, the walking light sits at bit 0 (0001), and the replay pointer is at entry 0.
- R2: While `en` is low, `leds` is 0000 in every mode; the recorded patterns, manual pattern, walker and replay pointer still update as they would with `en` high.
- R3: Mode code 0 (off) and the unused codes 5, 6 and 7 give `leds` = 0000.
- R4: Mode code 1 (default) shows one lit LED that moves by one position per cycle in which `tick` is high, in the order bit 0,1,2,3,2,1,0,1,...; in any cycle where the default behaviour is not in effect, the walker returns to bit 0 moving upward.
- R5: Mode code 2 (manual) shows a held pattern; a `wr_stb` in that mode loads `wr_pat` into it, visible from the next cycle, and it is kept until the next such strobe.
- R6: Mode code 3 (learn) stores `wr_pat` on each `wr_stb` as the next entry and grows the recorded length by one, up to 16 entries; strobes after the 16th are ignored. In this mode `leds` shows the most recently stored entry, or 0000 when nothing is stored.
- R7: The first cycle in learn mode after any other mode empties the recording; a strobe in that same cycle becomes entry 0.
- R8: Mode code 4 (replay) with at least one stored entry starts at entry 0, shows the entry at the pointer, advances one entry per `tick`, and returns to entry 0 after the last stored entry; the pointer returns to entry 0 whenever replay is not in effect.
- R9: Mode code 4 with an empty recording behaves exactly like the default mode, walking light included.
- R10: A strobe outside manual mode leaves the manual pattern unchanged, and a strobe outside learn mode leaves the recording unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Output enable; low blanks all LEDs |
| mode | input | 3 | Behaviour code: 0 off, 1 default, 2 manual, 3 learn, 4 replay, 5..7 dark |
| wr_stb | input | 1 | One-cycle write strobe for `wr_pat` |
| wr_pat | input | 4 | Pattern written by the host |
| tick | input | 1 | Step-rate pulse for walker and replay |
| leds | output | 4 | LED drive vector, 1 = lit |

## Verification
The bench drives long random runs where mode, enable, strobe and tick change independently, so mode switches land in the middle of walks, recordings and replays; these tell apart a walker or replay pointer that fails to restart on re-entry from one that restarts correctly. Directed runs fill the recording past its limit and replay it, separating a correct wrap after 16 entries from an overrun that lets a seventeenth pattern in. Short recordings of one and three entries check the wrap point against the recorded length rather than the memory size, and replay after an emptied recording separates the fallback to the walking light from a stale playback. Strobes issued in the wrong modes show whether manual and recorded state are properly guarded.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

  typedef enum logic [2:0] {
    MD_OFF     = 3'd0,
    MD_DEFAULT = 3'd1,
    MD_MANUAL  = 3'd2,
    MD_LEARN   = 3'd3,
    MD_REPLAY  = 3'd4
  } lmode_e;

  function automatic logic is_mode(input logic [2:0] code, input lmode_e m);
    return code == 3'(m);
  endfunction

endpackage

// File: rtl/led_seq_rec.sv
module led_seq_rec #(
  parameter int W     = 4,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       learn_act,
  input  logic                       learn_entry,
  input  logic                       wr_stb,
  input  logic [W-1:0]               wr_pat,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [$clog2(DEPTH+1)-1:0] len,
  output logic [W-1:0]               rd_pat,
  output logic [W-1:0]               tail_pat
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] base;
  logic             store;

  function automatic logic [PTR_W-1:0] tail_idx(input logic [LEN_W-1:0] n);
    return PTR_W'(n - 1'b1);
  endfunction

  assign base  = learn_entry ? '0 : len_q;
  assign store = learn_act && wr_stb && (base < FULL);

  always_ff @(posedge clk) begin
    if (store) mem[PTR_W'(base)] <= wr_pat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         len_q <= '0;
    else if (store)     len_q <= base + 1'b1;
    else if (learn_act) len_q <= base;
  end

  assign len      = len_q;
  assign rd_pat   = mem[rd_idx];
  assign tail_pat = (len_q == '0) ? '0 : mem[tail_idx(len_q)];

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= FULL);  // R6
  AST_LEARN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (learn_entry && !wr_stb) |=> (len_q == '0));  // R7
  AST_REC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !learn_act |=> $stable(len_q));  // R10
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (learn_act && !learn_entry && len_q == FULL) |=> (len_q == FULL));  // R6
endmodule

// File: rtl/led_seq_walk.sv
module led_seq_walk #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] walk
);
  localparam int POS_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [POS_W-1:0] TOP = POS_W'(W - 1);

  logic [POS_W-1:0] pos;
  logic             up;
  logic             step;

  assign step = run && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      up  <= 1'b1;
    end else if (!run) begin
      pos <= '0;
      up  <= 1'b1;
    end else if (step && W > 1) begin
      if (up) begin
        if (pos == TOP) begin
          pos <= pos - 1'b1;
          up  <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
        end
      end else begin
        if (pos == '0) begin
          pos <= pos + 1'b1;
          up  <= 1'b1;
        end else begin
          pos <= pos - 1'b1;
        end
      end
    end
  end

  assign walk = W'(1) << pos;

  AST_WALK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(walk) == 1);  // R4
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(pos));  // R4
  AST_WALK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos == '0 && up));  // R4
endmodule

// File: rtl/led_seq_play.sv
module led_seq_play #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       tick,
  input  logic [$clog2(DEPTH+1)-1:0] len,
  output logic [$clog2(DEPTH)-1:0]   rd_idx
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] rp;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] cur,
                                               input logic [LEN_W-1:0] n);
    logic [LEN_W-1:0] nxt;
    nxt = LEN_W'(cur) + 1'b1;
    return (nxt >= n) ? '0 : PTR_W'(nxt);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rp <= '0;
    else if (!run) rp <= '0;
    else if (tick) rp <= advance(rp, len);
  end

  assign rd_idx = rp;

  AST_RP_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (LEN_W'(rp) < len));  // R8
  AST_RP_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (rp == '0));  // R8
  AST_RP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (!run || $stable(rp)));  // R8
endmodule

// File: rtl/led_seq_top.sv
module led_seq_top #(
  parameter int NUM_LEDS = 4,
  parameter int DEPTH    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [2:0]          mode,
  input  logic                wr_stb,
  input  logic [NUM_LEDS-1:0] wr_pat,
  input  logic                tick,
  output logic [NUM_LEDS-1:0] leds
);
  import led_seq_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic [2:0]          prev_mode;
  logic [NUM_LEDS-1:0] man_q;
  logic                in_learn, in_manual, in_replay, in_default;
  logic                learn_entry, walk_run, play_run, man_load;
  logic [LEN_W-1:0]    len;
  logic [PTR_W-1:0]    rd_idx;
  logic [NUM_LEDS-1:0] rd_pat, tail_pat, walk;
  logic [NUM_LEDS-1:0] shown;

  assign in_learn    = is_mode(mode, MD_LEARN);
  assign in_manual   = is_mode(mode, MD_MANUAL);
  assign in_replay   = is_mode(mode, MD_REPLAY);
  assign in_default  = is_mode(mode, MD_DEFAULT);
  assign learn_entry = in_learn && !is_mode(prev_mode, MD_LEARN);
  assign play_run    = in_replay && (len != '0);
  assign walk_run    = in_default || (in_replay && len == '0);
  assign man_load    = in_manual && wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mode <= 3'(MD_OFF);
      man_q     <= '0;
    end else begin
      prev_mode <= mode;
      if (man_load) man_q <= wr_pat;
    end
  end

  led_seq_rec #(.W(NUM_LEDS), .DEPTH(DEPTH)) u_rec (
    .clk(clk), .rst_n(rst_n), .learn_act(in_learn), .learn_entry(learn_entry),
    .wr_stb(wr_stb), .wr_pat(wr_pat), .rd_idx(rd_idx), .len(len),
    .rd_pat(rd_pat), .tail_pat(tail_pat)
  );

  led_seq_walk #(.W(NUM_LEDS)) u_walk (
    .clk(clk), .rst_n(rst_n), .run(walk_run), .tick(tick), .walk(walk)
  );

  led_seq_play #(.DEPTH(DEPTH)) u_play (
    .clk(clk), .rst_n(rst_n), .run(play_run), .tick(tick), .len(len),
    .rd_idx(rd_idx)
  );

  always_comb begin
    shown = '0;
    if (walk_run)       shown = walk;
    else if (play_run)  shown = rd_pat;
    else if (in_manual) shown = man_q;
    else if (in_learn)  shown = tail_pat;
  end

  assign leds = en ? shown : '0;

  AST_MAN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !man_load |=> $stable(man_q));  // R10
  AST_MAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    man_load |=> (man_q == $past(wr_pat)));  // R5
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({walk_run, play_run, in_manual, in_learn}));  // R3
endmodule

// File: tb/tb_led_seq_top.sv
`timescale 1ns/1ps
module tb_led_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       wr_stb = 1'b0;
  logic [3:0] wr_pat = 4'd0;
  logic       tick = 1'b0;
  logic [3:0] leds;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  logic [3:0] r_mem [16];
  int r_len = 0, r_rp = 0, r_phase = 0, r_prev = 0;
  logic [3:0] r_man = 4'd0;

  always #2 clk = ~clk;

  led_seq_top dut (.clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
                   .wr_stb(wr_stb), .wr_pat(wr_pat), .tick(tick), .leds(leds));

  function automatic logic [3:0] phase_led(input int ph);
    int p;
    p = (ph < 4) ? ph : 6 - ph;
    return 4'(1 << p);
  endfunction

  function automatic logic [3:0] expect_leds();
    if (!en) return 4'd0;
    case (int'(mode))
      1: return phase_led(r_phase);
      2: return r_man;
      3: return (r_len == 0) ? 4'd0 : r_mem[r_len-1];
      4: return (r_len == 0) ? phase_led(r_phase) : r_mem[r_rp];
      default: return 4'd0;
    endcase
  endfunction

  function automatic string auto_tag();
    if (!en) return "R2";
    case (int'(mode))
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return (r_len == 0) ? "R9" : "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic model_step();
    int m;
    bit walking;
    m = int'(mode);
    walking = (m == 1) || (m == 4 && r_len == 0);
    if (!walking) r_phase = 0;
    else if (tick) r_phase = (r_phase + 1) % 6;
    if (m == 4 && r_len != 0) begin
      if (tick) r_rp = (r_rp + 1 >= r_len) ? 0 : r_rp + 1;
    end else r_rp = 0;
    if (m == 2 && wr_stb) r_man = wr_pat;
    if (m == 3) begin
      int n;
      n = (r_prev != 3) ? 0 : r_len;
      if (wr_stb && n < 16) begin
        r_mem[n] = wr_pat;
        r_len = n + 1;
      end else r_len = n;
    end
    r_prev = m;
  endtask

  task automatic cyc(input int m, input bit e, input bit s, input logic [3:0] p,
                     input bit t, input string tg = "");
    logic [3:0] exp;
    string tag;
    mode = 3'(m); en = e; wr_stb = s; wr_pat = p; tick = t;
    #1;
    exp = expect_leds();
    tag = (tg == "") ? auto_tag() : tg;
    checks++;
    if (leds !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d leds=%b expected=%b", tag, m, leds, exp);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state observed through each mode
    cyc(1, 1, 0, 0, 0, "R1");
    cyc(2, 1, 0, 0, 0, "R1");
    cyc(3, 1, 0, 0, 0, "R1");
    cyc(4, 1, 0, 0, 0, "R1");
    // R4 full walk
    for (int i = 0; i < 14; i++) cyc(1, 1, 0, 0, 1);
    // R5 manual load and hold, R2 blanking
    cyc(2, 1, 1, 4'b1010, 0);
    cyc(2, 1, 0, 4'b0000, 1);
    cyc(2, 0, 1, 4'b0110, 0, "R2");
    cyc(2, 1, 0, 0, 0, "R2");
    // R6 learn three entries, R10 manual untouched by learn strobes
    cyc(0, 1, 0, 0, 0, "R3");
    cyc(3, 1, 1, 4'b0011, 0);
    cyc(3, 1, 1, 4'b0101, 0);
    cyc(3, 1, 1, 4'b1001, 0);
    cyc(3, 1, 0, 0, 0);
    cyc(2, 1, 0, 0, 0, "R10");
    // R10 learn strobe outside learn mode
    cyc(4, 1, 1, 4'b1111, 0, "R10");
    for (int i = 0; i < 8; i++) cyc(4, 1, 0, 0, 1);
    // R7 re-entry empties recording
    cyc(3, 1, 0, 0, 0, "R7");
    cyc(3, 1, 0, 0, 0, "R7");
    cyc(4, 1, 0, 0, 1, "R9");
    cyc(4, 1, 0, 0, 1, "R9");
    // R7 strobe on entry becomes entry 0; single-entry replay
    cyc(3, 1, 1, 4'b0111, 0, "R7");
    cyc(3, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) cyc(4, 1, 0, 0, 1);
    // R6 overfill: 20 strobes, only 16 kept
    cyc(0, 1, 0, 0, 0);
    for (int i = 0; i < 20; i++) cyc(3, 1, 1, 4'(i + 3), 0, "R6");
    for (int i = 0; i < 40; i++) cyc(4, 1, 0, 0, 1, "R8");
    // unused codes
    for (int i = 5; i < 8; i++) cyc(i, 1, 1, 4'b1111, 1, "R3");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r, m;
      r = int'($urandom_range(0, 99));
      if (r < 20)      m = 1;
      else if (r < 38) m = 2;
      else if (r < 60) m = 3;
      else if (r < 92) m = 4;
      else             m = int'($urandom_range(0, 7));
      if (($urandom_range(0, 9) < 7) && i > 0) m = int'(mode);
      cyc(m, $urandom_range(0, 9) != 0, $urandom_range(0, 2) == 0,
          4'($urandom), $urandom_range(0, 1) == 1);
    end
    finish_run();
  end
endmodule